// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point datapath. It multiplies two 16-bit operands and folds the product into one of two 40-bit accumulators in a single clock. The product can load an accumulator, be added to it or be subtracted from it. The two square operations feed operand A to both multiplier inputs. Each operand is widened to 17 bits on its own signedness select, so the multiplier serves signed, unsigned and mixed operands. A fractional mode doubles the product to remove the repeated sign bit of a signed fraction.

An optional rounding step adds half of the low 16-bit field and then clears that field. The final value is checked against the 40-bit range. If it does not fit, it is either clamped to the nearest limit or wrapped, depending on the saturation enable. Each accumulator has its own zero flag and its own sticky overflow flag. Operands come from the surrounding datapath, and instruction decode happens upstream.

Top module: `mac_unit`

## Requirements
- R1: After reset both accumulators hold 0, both zero flags are 1 and both overflow flags are 0.
- R2: Each operand is widened to 17 bits. Bit 16 copies bit 15 when that operand's signed select is 1 and is 0 otherwise, so signed, unsigned and mixed operand pairs all multiply correctly.
- R3: The `op` port is 3 bits wide. Code 1 (MUL) loads the product into the destination. Code 2 (MAC) adds the product to the destination. Code 3 (MSU) subtracts the product from the destination. The new value appears on the accumulator port after the next rising clock edge.
- R4: Code 4 (SQA) adds opa·opa and code 5 (SQS) subtracts opa·opa. Both use the signed select of operand A, and `opb` and `b_signed` have no effect.
- R5: When `frac` is 1 the product is doubled before it is added or subtracted.
- R6: When `rnd` is 1, 2^15 is added to the full-precision result, and then bits 15..0 are cleared before the range check.
- R7: A result outside the signed 40-bit range sets the sticky overflow flag of the destination. The flag stays set through later writes and clears only when a MUL writes that accumulator without overflowing.
- R8: On overflow with `sat_en` = 1 the destination takes 0x7FFFFFFFFF if the true result is positive and 0x8000000000 if it is negative. With `sat_en` = 0 it takes the low 40 bits of the true result.
- R9: `dst_sel` = 0 writes accumulator 0 and `dst_sel` = 1 writes accumulator 1. The other accumulator and its flags are unchanged.
- R10: Codes 0, 6 and 7 leave both accumulators and all flags unchanged, whatever the other inputs are.
- R11: Each zero flag is 1 exactly when its accumulator holds 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B, not used by the square operations |
| op | input | 3 | Operation code (0 none, 1 MUL, 2 MAC, 3 MSU, 4 SQA, 5 SQS, 6/7 none) |
| a_signed | input | 1 | 1 treats operand A as two's complement |
| b_signed | input | 1 | 1 treats operand B as two's complement |
| rnd | input | 1 | Round to bit 16 and clear the low 16 bits |
| frac | input | 1 | Fractional mode: product doubled |
| sat_en | input | 1 | Clamp on overflow instead of wrapping |
| dst_sel | input | 1 | Destination accumulator select |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| zero0 | output | 1 | Accumulator 0 equals zero |
| zero1 | output | 1 | Accumulator 1 equals zero |
| ovf0 | output | 1 | Sticky overflow, accumulator 0 |
| ovf1 | output | 1 | Sticky overflow, accumulator 1 |

## Verification
The operand pair 0xFFFF × 0xFFFF is applied under all four signedness combinations. It gives 1, -65535 or 4294836225 depending on the selects, so any mistake in widening bit 16 shows up at once.

Rounding is tried on values just below, at and just above the 2^15 boundary, with both positive and negative signs. This separates a correct round from truncation and from round-toward-zero.

Long runs of full-scale fractional MAC and MSU drive each accumulator through both 40-bit limits, once with saturation and once without, which tells clamping from wrapping. The runs then continue to show that the overflow flag stays set until a MUL clears it. Writes to one accumulator, and the codes that do nothing, are each followed by a comparison of the accumulator and flags they must not touch.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MUL  = 3'd1,
    OP_MAC  = 3'd2,
    OP_MSU  = 3'd3,
    OP_SQA  = 3'd4,
    OP_SQS  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } mac_op_e;

  function automatic logic op_writes(input mac_op_e op);
    return (op == OP_MUL) || (op == OP_MAC) || (op == OP_MSU) ||
           (op == OP_SQA) || (op == OP_SQS);
  endfunction

  function automatic logic op_subtracts(input mac_op_e op);
    return (op == OP_MSU) || (op == OP_SQS);
  endfunction

  function automatic logic op_squares(input mac_op_e op);
    return (op == OP_SQA) || (op == OP_SQS);
  endfunction

  function automatic logic op_loads(input mac_op_e op);
    return (op == OP_MUL);
  endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep #(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0]    opa,
  input  logic [OPW-1:0]    opb,
  input  logic              a_signed,
  input  logic              b_signed,
  input  logic              square,
  output logic signed [OPW:0] mul_a,
  output logic signed [OPW:0] mul_b
);

  logic [OPW-1:0] src_b;
  logic           sgn_b;

  // square operations steer operand A onto both multiplier inputs
  assign src_b = square ? opa : opb;
  assign sgn_b = square ? a_signed : b_signed;

  // guard bit: copy of the top bit for signed operands, zero otherwise
  assign mul_a = {a_signed & opa[OPW-1], opa};
  assign mul_b = {sgn_b & src_b[OPW-1], src_b};

endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int OPW = 16,
  localparam int FW = 2*OPW + 2,
  localparam int PW = FW + 1
) (
  input  logic signed [OPW:0] mul_a,
  input  logic signed [OPW:0] mul_b,
  input  logic                frac,
  output logic [PW-1:0]       prod
);

  logic signed [FW-1:0] full;

  assign full = mul_a * mul_b;

  // fractional mode: drop the duplicated sign bit by doubling
  assign prod = frac ? {full, 1'b0} : {full[FW-1], full};

endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  localparam int PW  = 2*OPW + 3,
  localparam int SW  = ACCW + 2
) (
  input  logic [ACCW-1:0] acc_in,
  input  logic [PW-1:0]   prod,
  input  logic            load,
  input  logic            sub,
  input  logic            rnd,
  input  logic            sat_en,
  output logic [ACCW-1:0] res,
  output logic            ovf_evt,
  output logic            sat_hit
);

  localparam logic [SW-1:0]   ONE      = {{(SW-1){1'b0}}, 1'b1};
  localparam logic [SW-1:0]   RND_K    = ONE << (OPW-1);
  localparam logic [SW-1:0]   LOW_MASK = (ONE << OPW) - ONE;
  localparam logic [ACCW-1:0] POS_LIM  = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] NEG_LIM  = {1'b1, {(ACCW-1){1'b0}}};

  logic [SW-1:0] base_x, prod_x, sum, fin;

  always_comb begin
    base_x = load ? '0 : {{2{acc_in[ACCW-1]}}, acc_in};
    prod_x = {{(SW-PW){prod[PW-1]}}, prod};
    sum    = sub ? (base_x - prod_x) : (base_x + prod_x);
    fin    = rnd ? ((sum + RND_K) & ~LOW_MASK) : sum;
  end

  // the widened value always fits; it is out of range if its top three bits disagree
  assign ovf_evt = !((fin[SW-1] == fin[SW-2]) && (fin[SW-2] == fin[ACCW-1]));
  assign sat_hit = ovf_evt && sat_en;
  assign res     = sat_hit ? (fin[SW-1] ? NEG_LIM : POS_LIM) : fin[ACCW-1:0];

endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            restart,
  input  logic [ACCW-1:0] nxt,
  input  logic            ovf_evt,
  input  logic            sat_hit,
  input  logic            rnd,
  output logic [ACCW-1:0] acc,
  output logic            zero,
  output logic            ovf
);

  localparam logic [ACCW-1:0] POS_LIM = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] NEG_LIM = {1'b1, {(ACCW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      zero <= 1'b1;
      ovf  <= 1'b0;
    end else if (wr) begin
      acc  <= nxt;
      zero <= (nxt == '0);
      ovf  <= (ovf && !restart) || ovf_evt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(acc) && $stable(ovf) && $stable(zero))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr && restart)) |=> ovf); // R7
  AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ovf_evt) |=> ovf); // R7
  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sat_hit) |=> ((acc == POS_LIM) || (acc == NEG_LIM))); // R8
  AST_ROUND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rnd && !sat_hit) |=> (acc[OPW-1:0] == '0)); // R6
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> (acc == '0)); // R11

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int NACC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  input  logic [2:0]      op,
  input  logic            a_signed,
  input  logic            b_signed,
  input  logic            rnd,
  input  logic            frac,
  input  logic            sat_en,
  input  logic            dst_sel,
  output logic [ACCW-1:0] acc0,
  output logic [ACCW-1:0] acc1,
  output logic            zero0,
  output logic            zero1,
  output logic            ovf0,
  output logic            ovf1
);
  import mac_pkg::*;

  localparam int PW = 2*OPW + 3;

  mac_op_e                  op_e;
  logic                     wr_any, ld, sb, sq;
  logic signed [OPW:0]      mul_a, mul_b;
  logic [PW-1:0]            prod;
  logic [ACCW-1:0]          base, result;
  logic                     ovf_evt, sat_hit;
  logic [NACC-1:0]          wr_vec;
  logic [ACCW-1:0]          acc_q [NACC];
  logic [NACC-1:0]          zero_q, ovf_q;

  assign op_e   = mac_op_e'(op);
  assign wr_any = op_writes(op_e);
  assign ld     = op_loads(op_e);
  assign sb     = op_subtracts(op_e);
  assign sq     = op_squares(op_e);
  assign base   = acc_q[dst_sel];

  mac_operand_prep #(.OPW(OPW)) u_prep (
    .opa(opa), .opb(opb), .a_signed(a_signed), .b_signed(b_signed),
    .square(sq), .mul_a(mul_a), .mul_b(mul_b)
  );

  mac_multiplier #(.OPW(OPW)) u_mul (
    .mul_a(mul_a), .mul_b(mul_b), .frac(frac), .prod(prod)
  );

  mac_addsat #(.OPW(OPW), .ACCW(ACCW)) u_add (
    .acc_in(base), .prod(prod), .load(ld), .sub(sb), .rnd(rnd),
    .sat_en(sat_en), .res(result), .ovf_evt(ovf_evt), .sat_hit(sat_hit)
  );

  for (genvar gi = 0; gi < NACC; gi++) begin : g_acc
    assign wr_vec[gi] = wr_any && (dst_sel == gi[0]);
    mac_acc_bank #(.OPW(OPW), .ACCW(ACCW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(wr_vec[gi]), .restart(ld),
      .nxt(result), .ovf_evt(ovf_evt), .sat_hit(sat_hit), .rnd(rnd),
      .acc(acc_q[gi]), .zero(zero_q[gi]), .ovf(ovf_q[gi])
    );
  end

  assign acc0  = acc_q[0];
  assign acc1  = acc_q[1];
  assign zero0 = zero_q[0];
  assign zero1 = zero_q[1];
  assign ovf0  = ovf_q[0];
  assign ovf1  = ovf_q[1];

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R9
  AST_NOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> ($stable(acc0) && $stable(acc1))); // R10
  AST_DEST0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !dst_sel) |=> ($stable(acc1) && $stable(ovf1))); // R9
  AST_DEST1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && dst_sel) |=> ($stable(acc0) && $stable(ovf0))); // R9

endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  localparam int TCLK = 10;
  localparam longint MAXV = 64'sd549755813887;
  localparam longint MINV = -64'sd549755813888;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic [2:0]  op = '0;
  logic a_signed = 0, b_signed = 0, rnd = 0, frac = 0, sat_en = 0, dst_sel = 0;
  logic [39:0] acc0, acc1;
  logic zero0, zero1, ovf0, ovf1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  longint m_acc [2];
  bit     m_ovf [2];

  always #(TCLK/2) clk = ~clk;

  mac_unit u0 (.*);

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint sx40(input longint v);
    return (v <<< 24) >>> 24;
  endfunction

  task automatic check_all(input string tag);
    chk(tag, "acc0", sx40(longint'(acc0)), m_acc[0]);
    chk(tag, "acc1", sx40(longint'(acc1)), m_acc[1]);
    chk(tag, "zero0", longint'(zero0), longint'(m_acc[0] == 0));
    chk(tag, "zero1", longint'(zero1), longint'(m_acc[1] == 0));
    chk(tag, "ovf0", longint'(ovf0), longint'(m_ovf[0]));
    chk(tag, "ovf1", longint'(ovf1), longint'(m_ovf[1]));
  endtask

  // one operation: drive at a falling edge, let one rising edge pass, compare
  task automatic issue(input string tag, input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                       input bit as, input bit bs, input bit r, input bit f, input bit s, input bit d);
    longint ea, eb, p, v, bse;
    bit ov;
    @(negedge clk);
    op = o; opa = a; opb = b; a_signed = as; b_signed = bs;
    rnd = r; frac = f; sat_en = s; dst_sel = d;
    if (o >= 3'd1 && o <= 3'd5) begin
      ea = as ? longint'(signed'(a)) : longint'(a);
      if (o >= 3'd4) eb = ea;
      else eb = bs ? longint'(signed'(b)) : longint'(b);
      p = ea * eb;
      if (f) p = p * 2;
      bse = (o == 3'd1) ? 0 : m_acc[d];
      v = (o == 3'd3 || o == 3'd5) ? bse - p : bse + p;
      if (r) begin
        v = v + 32768;
        v = v - (v & 64'sd65535);
      end
      ov = (v > MAXV) || (v < MINV);
      m_ovf[d] = ((o == 3'd1) ? 1'b0 : m_ovf[d]) | ov;
      if (ov) m_acc[d] = s ? ((v > 0) ? MAXV : MINV) : sx40(v);
      else    m_acc[d] = v;
    end
    @(negedge clk);
    op = 3'd0;
    check_all(tag);
  endtask

  task automatic t_reset;
    m_acc[0] = 0; m_acc[1] = 0; m_ovf[0] = 0; m_ovf[1] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_signedness;
    issue("R2", 3'd1, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, 0);
    issue("R2", 3'd1, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, 0);
    issue("R2", 3'd1, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 0);
    issue("R2", 3'd1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    issue("R3", 3'd1, 16'd300, 16'd7, 1, 1, 0, 0, 0, 0);
    issue("R3", 3'd2, 16'hFFF6, 16'd11, 1, 1, 0, 0, 0, 0);
    issue("R3", 3'd3, 16'd1234, 16'd50, 0, 0, 0, 0, 0, 0);
    issue("R3", 3'd2, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_square;
    issue("R4", 3'd4, 16'hFFFD, 16'h1234, 1, 0, 0, 0, 0, 1);
    issue("R4", 3'd4, 16'hFFFD, 16'h0001, 0, 1, 0, 0, 0, 1);
    issue("R4", 3'd5, 16'd100, 16'hFFFF, 1, 1, 0, 0, 0, 1);
  endtask

  task automatic t_frac;
    issue("R5", 3'd1, 16'h4000, 16'h4000, 1, 1, 0, 1, 0, 0);
    issue("R5", 3'd2, 16'h8000, 16'h7FFF, 1, 1, 0, 1, 0, 0);
    issue("R5", 3'd5, 16'hC000, 16'h0000, 1, 1, 0, 1, 0, 0);
  endtask

  task automatic t_round;
    issue("R6", 3'd1, 16'd1, 16'h7FFF, 0, 0, 1, 0, 0, 0);
    issue("R6", 3'd1, 16'd1, 16'h8000, 0, 0, 1, 0, 0, 0);
    issue("R6", 3'd1, 16'd3, 16'h8001, 0, 0, 1, 0, 0, 0);
    issue("R6", 3'd1, 16'hFFFF, 16'h8000, 1, 0, 1, 0, 0, 0);
    issue("R6", 3'd1, 16'hFFFF, 16'h8001, 1, 0, 1, 0, 0, 0);
    issue("R6", 3'd2, 16'h1234, 16'h5678, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_overflow_sat;
    issue("R8", 3'd1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1, 1, 0);
    for (int i = 0; i < 70; i++) issue("R8", 3'd2, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1, 1, 0);
    issue("R7", 3'd3, 16'd5, 16'd5, 0, 0, 0, 0, 1, 0);
    issue("R7", 3'd1, 16'd2, 16'd2, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 70; i++) issue("R8", 3'd3, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1, 1, 0);
  endtask

  task automatic t_overflow_wrap;
    issue("R8", 3'd1, 16'd0, 16'd0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 70; i++) issue("R8", 3'd2, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1, 0, 1);
    issue("R7", 3'd2, 16'd1, 16'd1, 0, 0, 0, 0, 0, 1);
    issue("R7", 3'd1, 16'd9, 16'd9, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_dest_nop;
    issue("R9", 3'd1, 16'd77, 16'd3, 0, 0, 0, 0, 0, 1);
    issue("R9", 3'd2, 16'd5, 16'd5, 0, 0, 0, 0, 0, 0);
    issue("R10", 3'd0, 16'hFFFF, 16'hFFFF, 1, 1, 1, 1, 1, 0);
    issue("R10", 3'd6, 16'h1234, 16'h4321, 0, 0, 0, 0, 0, 1);
    issue("R10", 3'd7, 16'h8000, 16'h8000, 1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_zero;
    issue("R11", 3'd1, 16'd0, 16'hABCD, 0, 0, 0, 0, 0, 0);
    issue("R11", 3'd2, 16'd12, 16'd12, 0, 0, 0, 0, 0, 0);
    issue("R11", 3'd5, 16'd12, 16'd0, 0, 0, 0, 0, 0, 0);
    issue("R11", 3'd1, 16'd1, 16'd1, 0, 0, 1, 0, 0, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_signedness();
    t_basic();
    t_square();
    t_frac();
    t_round();
    t_overflow_sat();
    t_overflow_wrap();
    t_dest_nop();
    t_zero();
    finish_run();
  end

  initial begin
    #(TCLK * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule